// File: doc/BRIEF.md
# Block Transfer Micro-Op Sequencer

This block turns one block load or block store instruction into a fixed run of eight 8-byte memory micro-operations. At start it forms the effective base address from two operands. In register form the base is the sum of two register values. In immediate form it is a register value plus a sign-extended 13-bit immediate.

Before anything is issued, the block checks the request once for three faults: privilege, register-field legality and 64-byte alignment. A faulting request issues nothing. The block reports its fault code and `done_o` in the same cycle as the start strobe.

A clean request is latched, and the micro-ops are then offered one at a time on a valid/ready handshake. Each micro-op carries:
- its address, which is the base plus eight times its number;
- its register index, which is the register field plus its number;
- the load/store kind;
- a marker that is set only on the eighth micro-op.

One cycle after the eighth micro-op is accepted, `done_o` pulses with a fault code of zero.

Top module: `blkxfer_seq`

## Requirements
- R1: A clean request yields exactly eight micro-ops, numbered 0 to 7 in order. `mop_last_o` is 1 only on micro-op 7.
- R2: In register form (`use_imm_i`=0), micro-op n has address `rs1_i + rs2_i + 8*n`.
- R3: In immediate form (`use_imm_i`=1), micro-op n has address `rs1_i + sext(imm_i[12:0]) + 8*n`, where bit 12 of `imm_i` is the sign bit.
- R4: Micro-op n has register index `reg_field_i + n`, computed modulo 32. Bit 0 of the register field plays no part in the fault checks.
- R5: A privileged-action fault is raised when `priv_i` is 0 and either `asi_i[7]` is 0 or `asi_as_user_i` is 1. When `priv_i`=0 with `asi_i[7]`=1 and `asi_as_user_i`=0, the request runs normally.
- R6: An illegal-instruction fault is raised when any of `reg_field_i[3:1]` is nonzero.
- R7: A misalignment fault is raised when the low 6 bits of the effective base address are nonzero.
- R8: Fault codes on `fault_o` are 0 none, 1 privileged-action, 2 illegal-instruction and 3 misalignment. When several faults apply, the priority is 1, then 2, then 3. A faulting start asserts `done_o` with the code in the same cycle and issues no micro-op.
- R9: A micro-op advances only when `mop_valid_o` and `mop_ready_i` are both 1. While `mop_ready_i` is 0, the offered address, register index and kind stay stable.
- R10: A start strobe that arrives while a sequence is in progress is ignored. It produces no `done_o` and does not change the running sequence.
- R11: `done_o` is high for exactly one cycle, the cycle after micro-op 7 is accepted, with `fault_o`=0. Every micro-op's `mop_store_o` equals `is_store_i` as sampled at start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe for one block instruction |
| is_store_i | input | 1 | 1 = block store, 0 = block load |
| use_imm_i | input | 1 | 1 = immediate form, 0 = register form |
| rs1_i | input | 64 | First base operand |
| rs2_i | input | 64 | Second base operand (register form) |
| imm_i | input | 13 | Signed immediate (immediate form) |
| reg_field_i | input | 5 | Destination or source register field |
| priv_i | input | 1 | Processor privilege bit |
| asi_i | input | 8 | Address-space identifier |
| asi_as_user_i | input | 1 | Identifier is an as-if-user space |
| mop_valid_o | output | 1 | Micro-op offered |
| mop_ready_i | input | 1 | Micro-op accepted when high with valid |
| mop_addr_o | output | 64 | Micro-op byte address |
| mop_reg_o | output | 5 | Micro-op register index |
| mop_store_o | output | 1 | Micro-op kind, 1 = store |
| mop_last_o | output | 1 | Marks micro-op 7 |
| done_o | output | 1 | Instruction finished or faulted |
| fault_o | output | 2 | Fault code, meaningful with done_o |

## Verification
The assertions cover the stepping behaviour on every cycle:
- each accepted micro-op is followed by one whose address is 8 higher and whose register index is 1 higher;
- offered values stay stable under back-pressure;
- the last marker appears only on the eighth beat;
- the first micro-op is 64-byte aligned;
- a fault is never followed by an issued micro-op;
- the done pulse follows the final acceptance.

Only the bench's scenarios can show the rest. These are the absolute addresses produced by each operand form, including a negative immediate, and the exact fault code chosen for each combination of privilege, identifier and register field, including the priority cases. They also include the fact that a start during a running sequence leaves that sequence untouched.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;
   typedef enum logic [1:0] {
      FLT_NONE  = 2'd0,
      FLT_PRIV  = 2'd1,
      FLT_ILL   = 2'd2,
      FLT_ALIGN = 2'd3
   } flt_e;
endpackage

// File: rtl/blkxfer_ea.sv
// Effective base address: rs1 plus either rs2 or the sign-extended immediate.
module blkxfer_ea #(
   parameter int ADDR_W = 64,
   parameter int IMM_W  = 13
) (
   input  logic              use_imm,
   input  logic [ADDR_W-1:0] rs1,
   input  logic [ADDR_W-1:0] rs2,
   input  logic [IMM_W-1:0]  imm,
   output logic [ADDR_W-1:0] ea
);
   logic [ADDR_W-1:0] imm_ext;

   generate
      if (ADDR_W > IMM_W) begin : g_sext
         assign imm_ext = {{(ADDR_W-IMM_W){imm[IMM_W-1]}}, imm};
      end else begin : g_trunc
         assign imm_ext = imm[ADDR_W-1:0];
      end
   endgenerate

   assign ea = rs1 + (use_imm ? imm_ext : rs2);
endmodule

// File: rtl/blkxfer_chk.sv
// One-time fault evaluation with fixed priority.
module blkxfer_chk
   import blkxfer_pkg::*;
#(
   parameter int ADDR_W     = 64,
   parameter int REG_W      = 5,
   parameter int ASI_W      = 8,
   parameter int ALIGN_BITS = 6,
   parameter int RCHK_LO    = 1,
   parameter int RCHK_HI    = 3
) (
   input  logic              priv,
   input  logic [ASI_W-1:0]  asi,
   input  logic              as_user,
   input  logic [REG_W-1:0]  reg_field,
   input  logic [ADDR_W-1:0] ea,
   output flt_e              flt
);
   localparam logic [ASI_W-1:0]  ASI_PRIV_MASK = ASI_W'(1) << (ASI_W-1);
   localparam logic [REG_W-1:0]  REG_MASK      =
      REG_W'(((1 << (RCHK_HI-RCHK_LO+1)) - 1) << RCHK_LO);
   localparam logic [ADDR_W-1:0] ALIGN_MASK    = (ADDR_W'(1) << ALIGN_BITS) - ADDR_W'(1);

   logic priv_bad, reg_bad, align_bad;

   assign priv_bad  = !priv && (((asi & ASI_PRIV_MASK) == '0) || as_user);
   assign reg_bad   = (reg_field & REG_MASK) != '0;
   assign align_bad = (ea & ALIGN_MASK) != '0;

   always_comb begin
      if (priv_bad)       flt = FLT_PRIV;
      else if (reg_bad)   flt = FLT_ILL;
      else if (align_bad) flt = FLT_ALIGN;
      else                flt = FLT_NONE;
   end
endmodule

// File: rtl/blkxfer_ctl.sv
// Beat counter and busy/done control for the micro-op run.
module blkxfer_ctl #(
   parameter int NUM_OPS = 8,
   localparam int CNT_W  = $clog2(NUM_OPS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic             ready,
   output logic             busy,
   output logic [CNT_W-1:0] idx,
   output logic             last,
   output logic             done_q
);
   localparam logic [CNT_W-1:0] IDX_LAST = CNT_W'(NUM_OPS-1);

   assign last = busy && (idx == IDX_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         idx    <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (go) begin
            busy <= 1'b1;
            idx  <= '0;
         end else if (busy && ready) begin
            if (last) begin
               busy   <= 1'b0;
               idx    <= '0;
               done_q <= 1'b1;
            end else begin
               idx <= idx + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
   import blkxfer_pkg::*;
#(
   parameter int ADDR_W     = 64,
   parameter int IMM_W      = 13,
   parameter int REG_W      = 5,
   parameter int ASI_W      = 8,
   parameter int NUM_OPS    = 8,
   parameter int BEAT_BYTES = 8,
   parameter int RCHK_LO    = 1,
   parameter int RCHK_HI    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              is_store_i,
   input  logic              use_imm_i,
   input  logic [ADDR_W-1:0] rs1_i,
   input  logic [ADDR_W-1:0] rs2_i,
   input  logic [IMM_W-1:0]  imm_i,
   input  logic [REG_W-1:0]  reg_field_i,
   input  logic              priv_i,
   input  logic [ASI_W-1:0]  asi_i,
   input  logic              asi_as_user_i,
   output logic              mop_valid_o,
   input  logic              mop_ready_i,
   output logic [ADDR_W-1:0] mop_addr_o,
   output logic [REG_W-1:0]  mop_reg_o,
   output logic              mop_store_o,
   output logic              mop_last_o,
   output logic              done_o,
   output logic [1:0]        fault_o
);
   localparam int CNT_W      = $clog2(NUM_OPS);
   localparam int BEAT_SHIFT = $clog2(BEAT_BYTES);
   localparam int ALIGN_BITS = $clog2(NUM_OPS * BEAT_BYTES);

   generate
      if (NUM_OPS < 2 || (NUM_OPS & (NUM_OPS-1)) != 0) begin : g_bad_ops
         $error("NUM_OPS must be a power of two of at least 2");
      end
      if ((1 << BEAT_SHIFT) != BEAT_BYTES) begin : g_bad_beat
         $error("BEAT_BYTES must be a power of two");
      end
      if (ADDR_W <= IMM_W || ADDR_W <= ALIGN_BITS) begin : g_bad_addr
         $error("ADDR_W too narrow for immediate or alignment");
      end
      if (REG_W < CNT_W || RCHK_HI >= REG_W || RCHK_LO > RCHK_HI) begin : g_bad_reg
         $error("register field parameters inconsistent");
      end
   endgenerate

   logic [ADDR_W-1:0] ea;
   flt_e              flt;
   logic              busy, last, done_q, go, flt_evt;
   logic [CNT_W-1:0]  idx;
   logic [ADDR_W-1:0] base_q;
   logic [REG_W-1:0]  reg_q;
   logic              store_q;

   blkxfer_ea #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_ea (
      .use_imm (use_imm_i),
      .rs1     (rs1_i),
      .rs2     (rs2_i),
      .imm     (imm_i),
      .ea      (ea)
   );

   blkxfer_chk #(
      .ADDR_W(ADDR_W), .REG_W(REG_W), .ASI_W(ASI_W),
      .ALIGN_BITS(ALIGN_BITS), .RCHK_LO(RCHK_LO), .RCHK_HI(RCHK_HI)
   ) u_chk (
      .priv      (priv_i),
      .asi       (asi_i),
      .as_user   (asi_as_user_i),
      .reg_field (reg_field_i),
      .ea        (ea),
      .flt       (flt)
   );

   assign flt_evt = start_i && !busy && (flt != FLT_NONE);
   assign go      = start_i && !busy && (flt == FLT_NONE);

   blkxfer_ctl #(.NUM_OPS(NUM_OPS)) u_ctl (
      .clk    (clk),
      .rst_n  (rst_n),
      .go     (go),
      .ready  (mop_ready_i),
      .busy   (busy),
      .idx    (idx),
      .last   (last),
      .done_q (done_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q  <= '0;
         reg_q   <= '0;
         store_q <= 1'b0;
      end else if (go) begin
         base_q  <= ea;
         reg_q   <= reg_field_i;
         store_q <= is_store_i;
      end
   end

   assign mop_valid_o = busy;
   assign mop_addr_o  = base_q + (ADDR_W'(idx) << BEAT_SHIFT);
   assign mop_reg_o   = reg_q + REG_W'(idx);
   assign mop_store_o = store_q;
   assign mop_last_o  = last;
   assign done_o      = done_q || flt_evt;
   assign fault_o     = flt_evt ? flt : FLT_NONE;
endmodule

// File: rtl/blkxfer_seq_chk.sv
module blkxfer_seq_chk #(
   parameter int ADDR_W     = 64,
   parameter int REG_W      = 5,
   parameter int NUM_OPS    = 8,
   parameter int BEAT_BYTES = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              mop_valid_o,
   input logic              mop_ready_i,
   input logic [ADDR_W-1:0] mop_addr_o,
   input logic [REG_W-1:0]  mop_reg_o,
   input logic              mop_store_o,
   input logic              mop_last_o,
   input logic              done_o,
   input logic [1:0]        fault_o
);
   localparam int BW         = $clog2(NUM_OPS) + 1;
   localparam int ALIGN_BITS = $clog2(NUM_OPS * BEAT_BYTES);

   logic [BW-1:0] beats;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       beats <= '0;
      else if (!mop_valid_o)            beats <= '0;
      else if (mop_ready_i)             beats <= beats + 1'b1;
   end

   a_r1_last_on_final: assert property (@(posedge clk) disable iff (!rst_n)
      mop_valid_o && mop_last_o |-> beats == BW'(NUM_OPS-1));

   a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      mop_valid_o && mop_ready_i && !mop_last_o |=>
         mop_valid_o && mop_addr_o == $past(mop_addr_o) + ADDR_W'(BEAT_BYTES));

   a_r4_reg_step: assert property (@(posedge clk) disable iff (!rst_n)
      mop_valid_o && mop_ready_i && !mop_last_o |=>
         mop_reg_o == REG_W'($past(mop_reg_o) + 1'b1));

   a_r7_first_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mop_valid_o) |-> mop_addr_o[ALIGN_BITS-1:0] == '0);

   a_r8_fault_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && fault_o != 2'd0 |=> !mop_valid_o);

   a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      mop_valid_o && !mop_ready_i |=>
         mop_valid_o && $stable(mop_addr_o) && $stable(mop_reg_o) && $stable(mop_store_o));

   a_r10_start_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      mop_valid_o && start_i |-> !done_o);

   a_r11_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      mop_valid_o && mop_ready_i && mop_last_o |=>
         done_o && fault_o == 2'd0 && !mop_valid_o);
endmodule

bind blkxfer_seq blkxfer_seq_chk #(
   .ADDR_W(ADDR_W), .REG_W(REG_W), .NUM_OPS(NUM_OPS), .BEAT_BYTES(BEAT_BYTES)
) u_seq_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .mop_valid_o (mop_valid_o),
   .mop_ready_i (mop_ready_i),
   .mop_addr_o  (mop_addr_o),
   .mop_reg_o   (mop_reg_o),
   .mop_store_o (mop_store_o),
   .mop_last_o  (mop_last_o),
   .done_o      (done_o),
   .fault_o     (fault_o)
);

// File: tb/test_blkxfer_seq.sv
module test_blkxfer_seq;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0, is_store_i = 1'b0, use_imm_i = 1'b0;
   logic [63:0] rs1_i = '0, rs2_i = '0;
   logic [12:0] imm_i = '0;
   logic [4:0]  reg_field_i = '0;
   logic        priv_i = 1'b1;
   logic [7:0]  asi_i = 8'h80;
   logic        asi_as_user_i = 1'b0;
   logic        mop_valid_o, mop_ready_i = 1'b0;
   logic [63:0] mop_addr_o;
   logic [4:0]  mop_reg_o;
   logic        mop_store_o, mop_last_o, done_o;
   logic [1:0]  fault_o;

   int checks = 0;
   int fails  = 0;

   always #(CLK_P/2) clk = ~clk;

   blkxfer_seq i_blkxfer_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .is_store_i(is_store_i),
      .use_imm_i(use_imm_i), .rs1_i(rs1_i), .rs2_i(rs2_i), .imm_i(imm_i),
      .reg_field_i(reg_field_i), .priv_i(priv_i), .asi_i(asi_i),
      .asi_as_user_i(asi_as_user_i), .mop_valid_o(mop_valid_o),
      .mop_ready_i(mop_ready_i), .mop_addr_o(mop_addr_o), .mop_reg_o(mop_reg_o),
      .mop_store_o(mop_store_o), .mop_last_o(mop_last_o), .done_o(done_o),
      .fault_o(fault_o)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Runs one clean transfer and checks every beat plus the done pulse.
   task automatic run_xfer(input bit st, input bit imm_form, input logic [63:0] a,
                           input logic [63:0] b, input logic [12:0] im,
                           input logic [4:0] rf, input bit stall,
                           input bit poke_start, input string req);
      logic [63:0] base;
      int beats;
      int cyc;
      base = a + (imm_form ? {{51{im[12]}}, im} : b);
      @(negedge clk);
      is_store_i = st; use_imm_i = imm_form; rs1_i = a; rs2_i = b;
      imm_i = im; reg_field_i = rf; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      beats = 0;
      cyc = 0;
      while (beats < 8 && cyc < 64) begin
         mop_ready_i = stall ? cyc[0] : 1'b1;
         if (poke_start && cyc == 2) begin
            start_i = 1'b1; rs1_i = 64'h3; reg_field_i = 5'h06; priv_i = 1'b0;
            asi_i = 8'h00;
         end
         #1;
         chk(mop_valid_o == 1'b1, {req, " valid"}, 64'(mop_valid_o), 64'd1);
         chk(mop_addr_o == base + 64'(beats * 8), {req, " R2/R3 addr"},
             mop_addr_o, base + 64'(beats * 8));
         chk(mop_reg_o == 5'(rf + beats), {req, " R4 reg"}, 64'(mop_reg_o),
             64'(5'(rf + beats)));
         chk(mop_last_o == (beats == 7), {req, " R1 last"}, 64'(mop_last_o),
             64'(beats == 7));
         chk(mop_store_o == st, {req, " R11 kind"}, 64'(mop_store_o), 64'(st));
         if (poke_start && cyc == 2)
            chk(done_o == 1'b0, {req, " R10 start ignored"}, 64'(done_o), 64'd0);
         if (mop_ready_i) beats++;
         cyc++;
         @(negedge clk);
         start_i = 1'b0; priv_i = 1'b1; asi_i = 8'h80;
      end
      mop_ready_i = 1'b0;
      #1;
      chk(done_o == 1'b1 && fault_o == 2'd0, {req, " R11 done"},
          {62'd0, fault_o} | (64'(done_o) << 8), 64'h100);
      chk(mop_valid_o == 1'b0, {req, " R1 no ninth op"}, 64'(mop_valid_o), 64'd0);
      @(negedge clk);
      #1;
      chk(done_o == 1'b0, {req, " R11 single pulse"}, 64'(done_o), 64'd0);
   endtask

   // Issues a start expected to fault and checks the code and absence of ops.
   task automatic run_fault(input bit pv, input logic [7:0] asi, input bit usr,
                            input logic [4:0] rf, input logic [63:0] a,
                            input bit imm_form, input logic [12:0] im,
                            input logic [1:0] exp, input string req);
      @(negedge clk);
      priv_i = pv; asi_i = asi; asi_as_user_i = usr; reg_field_i = rf;
      rs1_i = a; rs2_i = 64'h0; use_imm_i = imm_form; imm_i = im; start_i = 1'b1;
      #1;
      chk(done_o == 1'b1, {req, " R8 done same cycle"}, 64'(done_o), 64'd1);
      chk(fault_o == exp, {req, " fault code"}, 64'(fault_o), 64'(exp));
      @(negedge clk);
      start_i = 1'b0; priv_i = 1'b1; asi_i = 8'h80; asi_as_user_i = 1'b0;
      #1;
      chk(mop_valid_o == 1'b0 && done_o == 1'b0, {req, " R8 nothing issued"},
          64'(mop_valid_o), 64'd0);
   endtask

   task automatic test_reset();
      #1;
      chk(mop_valid_o == 1'b0, "reset valid", 64'(mop_valid_o), 64'd0);
      chk(done_o == 1'b0 && fault_o == 2'd0, "reset done/fault", 64'(done_o), 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      // R2 register-form load, ready held high
      run_xfer(1'b0, 1'b0, 64'h1000, 64'h40, 13'h0, 5'h00, 1'b0, 1'b0, "R2 load");
      // R3 immediate-form store, negative immediate, R9 back-pressure
      run_xfer(1'b1, 1'b1, 64'h2000, 64'h0, 13'h1FC0, 5'h10, 1'b1, 1'b0, "R3 R9 store");
      // R4 bit 0 ignored; R5 user mode with privileged-space bit set runs
      @(negedge clk);
      priv_i = 1'b0; asi_i = 8'h80;
      run_xfer(1'b0, 1'b0, 64'h0, 64'h3C0, 13'h0, 5'h11, 1'b0, 1'b0, "R4 R5 ok");
      priv_i = 1'b1;
      // R10 start during a running sequence
      run_xfer(1'b1, 1'b0, 64'h8000, 64'h0, 13'h0, 5'h00, 1'b1, 1'b1, "R10 busy");
      // R5 privileged-action faults
      run_fault(1'b0, 8'h7F, 1'b0, 5'h00, 64'h0, 1'b0, 13'h0, 2'd1, "R5 low asi");
      run_fault(1'b0, 8'h80, 1'b1, 5'h00, 64'h0, 1'b0, 13'h0, 2'd1, "R5 as-user");
      // R6 illegal-instruction faults
      run_fault(1'b1, 8'h80, 1'b0, 5'h02, 64'h0, 1'b0, 13'h0, 2'd2, "R6 bit1");
      run_fault(1'b1, 8'h80, 1'b0, 5'h08, 64'h0, 1'b0, 13'h0, 2'd2, "R6 bit3");
      // R7 misalignment faults
      run_fault(1'b1, 8'h80, 1'b0, 5'h00, 64'h1004, 1'b0, 13'h0, 2'd3, "R7 reg form");
      run_fault(1'b1, 8'h80, 1'b0, 5'h00, 64'h1000, 1'b1, 13'h0008, 2'd3, "R7 imm form");
      // R8 priority
      run_fault(1'b0, 8'h00, 1'b0, 5'h02, 64'h1001, 1'b0, 13'h0, 2'd1, "R8 all three");
      run_fault(1'b1, 8'h80, 1'b0, 5'h04, 64'h1001, 1'b0, 13'h0, 2'd2, "R8 ill+align");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(CLK_P * 200000);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule